// File: doc/BRIEF.md
# Serial Memory Streaming Read Engine

This block is the device-side decoder for the read command of a serial memory that is accessed over a four-wire SPI link in mode 0. While chip select is low it collects an 8-bit command and a 16-bit byte address from the serial input. When the command is a read, it fetches bytes from a synchronous single-port memory and returns them on the serial output, most significant bit first. Every command other than read is treated as a no-op until the end of the transaction.

The engine keeps streaming for as long as chip select stays low. After each byte it steps the address by one, and past the top of the array the address returns to zero, so one transaction can cover the whole array. All logic runs on a fast system clock. The serial clock, chip select and serial input are synchronised into that domain and used only as sampled edges. To leave room for the synchroniser and one memory fetch, each SCK phase must last at least SYNC_STAGES+3 system clocks.

Top module: `spi_read_engine`

## Requirements
- R1: While chip select is high, and after reset, `so_oe`, `so` and `mem_rd` are all low.
- R2: The first 8 SI bits of a transaction form the command and the next 16 bits form the address, both sampled on rising SCK with the MSB first. The command 0x03 selects read. Only the low ADDR_W (15) address bits are used and the top bit is ignored.
- R3: Read data leaves on `so` starting with bit 7 and ending with bit 0. `so` changes only after a falling SCK edge, and `so_oe` is high from the first data falling edge until chip select rises.
- R4: While chip select stays low, the byte at the next address follows the previous byte with no gap in the bit stream.
- R5: After address 2^ADDR_W-1 the stream continues with address 0.
- R6: SI values during the data phase have no effect on the returned data.
- R7: After any command other than 0x03, `so_oe` and `mem_rd` stay low until chip select goes high.
- R8: Chip select rising at any point, whether mid-address or mid-byte, returns the engine to idle. The next transaction is decoded from its first bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | Serial clock, idles low |
| cs_n | input | 1 | Active-low chip select |
| si | input | 1 | Serial data into the engine |
| so | output | 1 | Serial data out of the engine, 0 when not enabled |
| so_oe | output | 1 | Output enable for `so` |
| mem_addr | output | ADDR_W | Memory read address |
| mem_rd | output | 1 | Memory read strobe; data is expected one clock later |
| mem_rdata | input | 8 | Memory read data |

## Verification
An SCK edge takes SYNC_STAGES+1 system clocks to become an internal pulse, and `so` moves one clock after that. So a new output bit settles about four clocks after SCK falls, while the bench holds each SCK phase for eight clocks. The monitor samples `so` only on rising SCK, when that bit has long been stable. A memory fetch returns two clocks after the address phase ends or a byte is loaded, which is well before the next falling edge. Checks on chip-select release wait six clocks, which covers the synchroniser and the state register.

// File: rtl/spi_rd_pkg.sv
package spi_rd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_ADDR,
        ST_DATA,
        ST_SKIP
    } rd_state_e;

    localparam int CMD_BITS  = 8;
    localparam int ADR_BITS  = 16;
    localparam int BYTE_BITS = 8;

endpackage

// File: rtl/spi_rd_sync.sv
module spi_rd_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    input  logic cs_n,
    input  logic si,
    output logic sck_rise,
    output logic sck_fall,
    output logic cs_act,
    output logic si_s
);
    // bit order inside each stage: {sck, cs_n, si}
    localparam logic [2:0] IDLE_V = 3'b010;

    logic [2:0] stg_q [STAGES];
    logic       sck_prev_q;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg_q[g] <= IDLE_V;
                else        stg_q[g] <= {sck, cs_n, si};
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg_q[g] <= IDLE_V;
                else        stg_q[g] <= stg_q[g-1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sck_prev_q <= 1'b0;
        else        sck_prev_q <= stg_q[STAGES-1][2];
    end

    assign sck_rise = stg_q[STAGES-1][2] & ~sck_prev_q;
    assign sck_fall = ~stg_q[STAGES-1][2] & sck_prev_q;
    assign cs_act   = ~stg_q[STAGES-1][1];
    assign si_s     = stg_q[STAGES-1][0];

endmodule

// File: rtl/spi_rd_ctrl.sv
module spi_rd_ctrl
    import spi_rd_pkg::*;
#(
    parameter int          ADDR_W  = 15,
    parameter logic [7:0]  RD_OP   = 8'h03
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_act,
    input  logic              sck_rise,
    input  logic              sck_fall,
    input  logic              si_s,
    input  logic [7:0]        mem_rdata,
    output logic              so,
    output logic              so_oe,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd
);
    localparam int CNT_W = $clog2(ADR_BITS + 1);

    typedef struct packed {
        rd_state_e             state;
        logic [CNT_W-1:0]      cnt;
        logic [ADR_BITS-1:0]   sh;
        logic [ADDR_W-1:0]     addr;
        logic [BYTE_BITS-1:0]  sreg;
        logic [BYTE_BITS-1:0]  buffer;
        logic                  rd;
        logic                  pend;
        logic                  live;
    } ctrl_t;

    ctrl_t r_q, r_d;

    logic [ADR_BITS-1:0] sh_in;
    assign sh_in = {r_q.sh[ADR_BITS-2:0], si_s};

    always_comb begin
        r_d      = r_q;
        r_d.rd   = 1'b0;
        r_d.pend = r_q.rd;
        if (r_q.pend) r_d.buffer = mem_rdata;

        unique case (r_q.state)
            ST_IDLE: begin
                if (cs_act) begin
                    r_d.state = ST_CMD;
                    r_d.cnt   = '0;
                    r_d.live  = 1'b0;
                end
            end
            ST_CMD: begin
                if (sck_rise) begin
                    r_d.sh  = sh_in;
                    r_d.cnt = r_q.cnt + 1'b1;
                    if (r_q.cnt == CNT_W'(CMD_BITS - 1)) begin
                        r_d.cnt   = '0;
                        r_d.state = (sh_in[7:0] == RD_OP) ? ST_ADDR : ST_SKIP;
                    end
                end
            end
            ST_ADDR: begin
                if (sck_rise) begin
                    r_d.sh  = sh_in;
                    r_d.cnt = r_q.cnt + 1'b1;
                    if (r_q.cnt == CNT_W'(ADR_BITS - 1)) begin
                        r_d.cnt   = '0;
                        r_d.addr  = sh_in[ADDR_W-1:0];
                        r_d.rd    = 1'b1;
                        r_d.state = ST_DATA;
                    end
                end
            end
            ST_DATA: begin
                if (sck_fall) begin
                    if (r_q.cnt[2:0] == 3'd0) begin
                        r_d.sreg = r_q.buffer;
                        r_d.addr = r_q.addr + 1'b1;
                        r_d.rd   = 1'b1;
                        r_d.live = 1'b1;
                    end else begin
                        r_d.sreg = {r_q.sreg[BYTE_BITS-2:0], 1'b0};
                    end
                    r_d.cnt = CNT_W'(3'(r_q.cnt[2:0] + 3'd1));
                end
            end
            default: ;
        endcase

        if (!cs_act) begin
            r_d.state = ST_IDLE;
            r_d.cnt   = '0;
            r_d.live  = 1'b0;
            r_d.rd    = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign so_oe    = (r_q.state == ST_DATA) && r_q.live;
    assign so       = so_oe ? r_q.sreg[BYTE_BITS-1] : 1'b0;
    assign mem_addr = r_q.addr;
    assign mem_rd   = r_q.rd;

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> (!so_oe && !mem_rd));

    // R7
    skip_no_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_SKIP) |-> (!mem_rd && !so_oe));

    // R3
    so_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (so_oe && $past(so_oe) && !$past(sck_fall)) |-> $stable(so));

    // R4 R5
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && r_q.state == ST_DATA && $past(r_q.state) == ST_DATA)
        |-> (mem_addr == ADDR_W'($past(mem_addr) + 1'b1)));

endmodule

// File: rtl/spi_read_engine.sv
module spi_read_engine #(
    parameter int         ADDR_W      = 15,
    parameter int         SYNC_STAGES = 2,
    parameter logic [7:0] RD_OP       = 8'h03
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck,
    input  logic              cs_n,
    input  logic              si,
    output logic              so,
    output logic              so_oe,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    input  logic [7:0]        mem_rdata
);
    logic sck_rise, sck_fall, cs_act, si_s;

    spi_rd_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .sck      (sck),
        .cs_n     (cs_n),
        .si       (si),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall),
        .cs_act   (cs_act),
        .si_s     (si_s)
    );

    spi_rd_ctrl #(.ADDR_W(ADDR_W), .RD_OP(RD_OP)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_act    (cs_act),
        .sck_rise  (sck_rise),
        .sck_fall  (sck_fall),
        .si_s      (si_s),
        .mem_rdata (mem_rdata),
        .so        (so),
        .so_oe     (so_oe),
        .mem_addr  (mem_addr),
        .mem_rd    (mem_rd)
    );

endmodule

// File: tb/sim_spi_read_engine.sv
module sim_spi_read_engine;
    localparam int AW = 15;
    localparam int H  = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0, cs_n = 1'b1, si = 1'b0;
    logic so, so_oe, mem_rd;
    logic [AW-1:0] mem_addr;
    logic [7:0] mem_rdata = 8'h00;

    int n_chk = 0, n_bad = 0;
    logic [7:0] exp_q [$];
    logic data_phase = 1'b0;
    int mon_bits = 0;
    logic [7:0] got = 8'h00;
    logic watch = 1'b0;
    int act_cnt = 0;
    string cur_req = "R3";

    always #4 clk = ~clk;

    spi_read_engine u0 (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si),
        .so(so), .so_oe(so_oe), .mem_addr(mem_addr), .mem_rd(mem_rd),
        .mem_rdata(mem_rdata)
    );

    function automatic logic [7:0] mval(input logic [AW-1:0] a);
        return 8'(a[7:0] * 8'd13) ^ {1'b0, a[14:8]} ^ 8'hA5;
    endfunction

    always @(posedge clk) if (mem_rd) mem_rdata <= mval(mem_addr);

    always @(posedge clk) if (watch && (so_oe || mem_rd)) act_cnt++;

    task automatic chk(input logic ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // monitor: collects SO bits on rising SCK and pops the scoreboard
    always @(posedge sck) begin
        if (data_phase) begin
            got = {got[6:0], so};
            mon_bits++;
            if (mon_bits == 8) begin
                mon_bits = 0;
                if (exp_q.size() == 0) chk(1'b0, cur_req, int'(got), -1);
                else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    chk(got == e && so_oe, cur_req, int'(got), int'(e));
                end
            end
        end
    end

    task automatic bit_out(input logic b);
        si = b;
        repeat (H) @(negedge clk);
        sck = 1'b1;
        repeat (H) @(negedge clk);
        sck = 1'b0;
    endtask

    task automatic release_cs();
        repeat (H) @(negedge clk);
        cs_n = 1'b1;
        repeat (4 * H) @(negedge clk);
    endtask

    // driver: sends command+address, pushes expected bytes, clocks data phase
    task automatic read_txn(input logic [7:0] op, input logic [15:0] aw,
                            input int nbytes, input int extra, input logic fill);
        cs_n = 1'b0;
        repeat (H) @(negedge clk);
        for (int i = 7; i >= 0; i--) bit_out(op[i]);
        for (int i = 15; i >= 0; i--) bit_out(aw[i]);
        if (op == 8'h03) begin
            for (int b = 0; b < nbytes; b++) exp_q.push_back(mval(AW'(aw[AW-1:0] + b)));
            mon_bits = 0;
            data_phase = 1'b1;
        end
        for (int k = 0; k < nbytes * 8; k++) bit_out(fill ? ((k % 8) >= 6) : 1'b0);
        data_phase = 1'b0;
        for (int k = 0; k < extra; k++) bit_out(1'b1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        // R1 reset state
        chk(!so_oe && !so && !mem_rd, "R1", {so_oe, so, mem_rd}, 0);

        // R2 R3 R4 plain stream
        cur_req = "R4";
        read_txn(8'h03, 16'h0123, 5, 0, 1'b0);
        release_cs();
        chk(exp_q.size() == 0, "R4", exp_q.size(), 0);
        chk(!so_oe && !mem_rd, "R1", {so_oe, mem_rd}, 0);

        // R5 wrap, with address MSB set (R2 ignores it)
        cur_req = "R5";
        read_txn(8'h03, 16'hFFFE, 4, 0, 1'b0);
        release_cs();
        chk(exp_q.size() == 0, "R5", exp_q.size(), 0);

        // R6 SI carries read-command pattern during data
        cur_req = "R6";
        read_txn(8'h03, 16'h4000, 3, 0, 1'b1);
        release_cs();
        chk(exp_q.size() == 0, "R6", exp_q.size(), 0);

        // R7 non-read command
        watch = 1'b1; act_cnt = 0;
        read_txn(8'h02, 16'h0010, 2, 0, 1'b1);
        release_cs();
        watch = 1'b0;
        chk(act_cnt == 0, "R7", act_cnt, 0);

        // R8 abort mid-byte
        cur_req = "R8";
        read_txn(8'h03, 16'h0200, 1, 3, 1'b0);
        cs_n = 1'b1;
        repeat (6) @(negedge clk);
        chk(!so_oe && !so, "R8", {so_oe, so}, 0);
        repeat (4 * H) @(negedge clk);
        read_txn(8'h03, 16'h0300, 2, 0, 1'b0);
        release_cs();
        chk(exp_q.size() == 0, "R8", exp_q.size(), 0);

        // R8 abort mid-address, then fresh read
        cs_n = 1'b0;
        repeat (H) @(negedge clk);
        for (int i = 7; i >= 0; i--) bit_out(1'(8'h03 >> i));
        for (int i = 0; i < 5; i++) bit_out(1'b1);
        release_cs();
        chk(!so_oe && !mem_rd, "R8", {so_oe, mem_rd}, 0);
        read_txn(8'h03, 16'h7ABC, 2, 0, 1'b0);
        release_cs();
        chk(exp_q.size() == 0, "R8", exp_q.size(), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule